// File: doc/BRIEF.md
# Station Address Bank with Cross-Domain Transfer

This block keeps a set of 48-bit station addresses. Software programs them through a 32-bit register port in the host clock domain. The receive and transmit datapaths read them from copies held in a separate, unrelated line clock domain. Each address takes up two host words. The upper word holds address bits 47:32 in its bits 15:0. The lower word holds address bits 31:0.

Not every write causes a transfer. A new address moves into the line domain only when a write to the lower word includes the designated trigger byte lane. The `trig_lane_big` input selects that lane. On a trigger, the complete 48-bit host value is frozen in a per-entry holding register. A single toggle flag then crosses a two-flop synchronizer. When the line domain sees the edge of that flag, it loads all 48 bits at once. All other writes change only the host-side copy.

Software must space trigger writes to the same entry at least four line clock cycles apart. Reads return the host-side copy one host cycle after the read strobe. The entry count must be at least two.

Top module: `station_addr_bank`

## Requirements
- R1: A low level on `host_rst_n`, sampled on a `host_clk` edge, sets every host-side entry to all ones, so the upper word reads 0x0000FFFF and the lower word reads 0xFFFFFFFF. A low level on `line_rst_n`, sampled on a `line_clk` edge, sets every line-side copy to 48'hFFFFFFFFFFFF.
- R2: Entry i has its upper word at word address 2*i and its lower word at word address 2*i+1. The upper word bits 15:0 hold address bits 47:32. The lower word holds address bits 31:0. Each write strobe reaches exactly one register.
- R3: A write changes only the byte lanes whose `host_be` bit is set. Lane k is data bits 8k+7:8k. A read strobe returns the addressed host-side word on `host_rdata` one `host_clk` edge later, and that value is held until the next read.
- R4: Bits 31:16 of every upper word read as zero, and writes to them are ignored.
- R5: With `trig_lane_big`=0, a write to a lower word with `host_be[3]` set starts a transfer of that entry.
- R6: With `trig_lane_big`=1, a write to a lower word with `host_be[0]` set starts a transfer of that entry. A write with only `host_be[3]` set does not start one.
- R7: Writes to an upper word, and lower-word writes without the trigger lane, leave the line-side copy unchanged.
- R8: After a trigger write, the line-side copy shows the new value by the fourth rising `line_clk` edge following the `host_clk` edge that took the write.
- R9: A line-side copy only ever changes to the exact value captured at a trigger. All 48 bits change in the same `line_clk` cycle, and no mix of old and new bits ever appears.
- R10: The transferred value is the stored upper word together with the lower word as merged by the trigger write itself.
- R11: A transfer of one entry leaves every other entry's line-side copy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host register clock |
| host_rst_n | input | 1 | Synchronous active-low reset, host domain |
| host_wr_en | input | 1 | Write strobe |
| host_rd_en | input | 1 | Read strobe |
| host_addr | input | ADDR_W | Word address, entry index in bits above bit 0 |
| host_wdata | input | 32 | Write data |
| host_be | input | 4 | Byte-lane enables for writes |
| trig_lane_big | input | 1 | 0: lane 3 triggers, 1: lane 0 triggers |
| host_rdata | output | 32 | Registered read data |
| line_clk | input | 1 | Line-side clock |
| line_rst_n | input | 1 | Synchronous active-low reset, line domain |
| line_addr_flat | output | NUM_ENTRIES*48 | Line-side copies, entry i in bits 48i+47:48i |

## Verification
Assertions check several rules on every cycle. The handshake flag toggles exactly on trigger writes. The holding register and each line copy stay still unless a transfer is in progress. A line copy loads exactly the held value. Upper-word reads carry zeros in bits 31:16. Other properties span the two clocks, so only the bench scenarios can show them: the end-to-end latency bound, that line copies never show torn values while the two clocks run at unrelated periods, that trigger-lane selection follows the mode, and that entries do not affect each other.

// File: rtl/sab_pkg.sv
// Shared constants and helpers for the station address bank.
// Assumes 32-bit host words and 48-bit addresses split 16/32.
package sab_pkg;
    localparam int WORD_W   = 32;
    localparam int STA_W    = 48;
    localparam int HI_W     = STA_W - WORD_W;
    localparam int LANE_W   = 8;
    localparam int LANES    = WORD_W / LANE_W;
    localparam int HI_LANES = HI_W / LANE_W;

    typedef logic [STA_W-1:0] sta_addr_t;

    localparam sta_addr_t STA_RESET = '1;

    typedef enum logic {
        TRIG_LANE_TOP = 1'b0,
        TRIG_LANE_LOW = 1'b1
    } trig_lane_e;
endpackage

// File: rtl/sab_host_entry.sv
// Host-side storage for one address entry: upper and lower words with
// byte-lane merge, trigger detection, holding register and toggle flag.
// Assumes wr_hi and wr_lo are never asserted together.
module sab_host_entry
    import sab_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    input  logic              trig_lane_big,
    output logic [HI_W-1:0]   hi_q,
    output logic [WORD_W-1:0] lo_q,
    output sta_addr_t         hold_q,
    output logic              flag_q
);
    logic [HI_W-1:0]   hi_next;
    logic [WORD_W-1:0] lo_next;
    logic              trig;

    // Merge enabled byte lanes into the upper word (only its low lanes exist).
    for (genvar l = 0; l < HI_LANES; l++) begin : g_hi_lane
        assign hi_next[l*LANE_W +: LANE_W] =
            wr_be[l] ? wr_data[l*LANE_W +: LANE_W] : hi_q[l*LANE_W +: LANE_W];
    end

    // Merge enabled byte lanes into the lower word.
    for (genvar l = 0; l < LANES; l++) begin : g_lo_lane
        assign lo_next[l*LANE_W +: LANE_W] =
            wr_be[l] ? wr_data[l*LANE_W +: LANE_W] : lo_q[l*LANE_W +: LANE_W];
    end

    // Trigger: lower-word write that covers the mode's trigger lane.
    always_comb begin
        if (trig_lane_big == TRIG_LANE_LOW) trig = wr_lo & wr_be[0];
        else                                trig = wr_lo & wr_be[LANES-1];
    end

    // Host-side registers, holding register and handshake toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '1;
            lo_q   <= '1;
            hold_q <= STA_RESET;
            flag_q <= 1'b0;
        end else begin
            if (wr_hi) hi_q <= hi_next;
            if (wr_lo) lo_q <= lo_next;
            if (trig) begin
                hold_q <= {hi_q, lo_next};
                flag_q <= ~flag_q;
            end
        end
    end

    AST_FLAG_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (flag_q != $past(flag_q)));                             // R5
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> ($stable(flag_q) && $stable(hold_q)));                 // R7
    AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (hold_q == {$past(hi_q), lo_q}));                       // R10
endmodule

// File: rtl/sab_toggle_sync.sv
// Two-flop synchronizer for a toggle flag, plus an edge detector that
// emits a one-cycle load pulse in the destination domain.
// Assumes the flag toggles at most once per four destination cycles.
module sab_toggle_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic pulse
);
    logic meta_q;
    logic sync_q;
    logic last_q;

    // Synchronizer chain and previous-value register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= tog_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign pulse = sync_q ^ last_q;
endmodule

// File: rtl/sab_line_entry.sv
// Line-side copy of one address entry; loads the held value as a whole
// on a load pulse. Assumes hold_in is stable while load can occur.
module sab_line_entry
    import sab_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  sta_addr_t hold_in,
    output sta_addr_t addr_q
);
    // Whole-entry load register.
    always_ff @(posedge clk) begin
        if (!rst_n)    addr_q <= STA_RESET;
        else if (load) addr_q <= hold_in;
    end

    AST_LINE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_q));                                      // R7
    AST_LINE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr_q == $past(hold_in)));                            // R9
endmodule

// File: rtl/station_addr_bank.sv
// Bank of NUM_ENTRIES station addresses: host register decode and read
// mux, per-entry host storage, toggle synchronizers and line-side copies.
// Assumes NUM_ENTRIES >= 2 and a static trig_lane_big setting.
module station_addr_bank
    import sab_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int ADDR_W      = $clog2(2 * NUM_ENTRIES)
) (
    input  logic                         host_clk,
    input  logic                         host_rst_n,
    input  logic                         host_wr_en,
    input  logic                         host_rd_en,
    input  logic [ADDR_W-1:0]            host_addr,
    input  logic [31:0]                  host_wdata,
    input  logic [3:0]                   host_be,
    input  logic                         trig_lane_big,
    output logic [31:0]                  host_rdata,
    input  logic                         line_clk,
    input  logic                         line_rst_n,
    output logic [NUM_ENTRIES*48-1:0]    line_addr_flat
);
    localparam int IDX_W = ADDR_W - 1;

    logic [IDX_W-1:0]  sel_idx;
    logic              sel_lo;
    logic              sel_ok;
    logic [NUM_ENTRIES-1:0] wr_hi_vec;
    logic [NUM_ENTRIES-1:0] wr_lo_vec;
    logic [HI_W-1:0]   hi_arr   [NUM_ENTRIES];
    logic [WORD_W-1:0] lo_arr   [NUM_ENTRIES];
    sta_addr_t         hold_arr [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] flag_vec;
    logic [NUM_ENTRIES-1:0] load_vec;

    assign sel_idx = host_addr[ADDR_W-1:1];
    assign sel_lo  = host_addr[0];
    assign sel_ok  = (int'(sel_idx) < NUM_ENTRIES);

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
        // Per-entry write strobes from the word address.
        assign wr_hi_vec[e] = host_wr_en && (int'(sel_idx) == e) && !sel_lo;
        assign wr_lo_vec[e] = host_wr_en && (int'(sel_idx) == e) &&  sel_lo;

        sab_host_entry u_host (
            .clk           (host_clk),
            .rst_n         (host_rst_n),
            .wr_hi         (wr_hi_vec[e]),
            .wr_lo         (wr_lo_vec[e]),
            .wr_data       (host_wdata),
            .wr_be         (host_be),
            .trig_lane_big (trig_lane_big),
            .hi_q          (hi_arr[e]),
            .lo_q          (lo_arr[e]),
            .hold_q        (hold_arr[e]),
            .flag_q        (flag_vec[e])
        );

        sab_toggle_sync u_sync (
            .clk    (line_clk),
            .rst_n  (line_rst_n),
            .tog_in (flag_vec[e]),
            .pulse  (load_vec[e])
        );

        sab_line_entry u_line (
            .clk     (line_clk),
            .rst_n   (line_rst_n),
            .load    (load_vec[e]),
            .hold_in (hold_arr[e]),
            .addr_q  (line_addr_flat[e*STA_W +: STA_W])
        );
    end

    // Registered read mux returning host-side copies.
    always_ff @(posedge host_clk) begin
        if (!host_rst_n) begin
            host_rdata <= '0;
        end else if (host_rd_en) begin
            if (!sel_ok)     host_rdata <= '0;
            else if (sel_lo) host_rdata <= lo_arr[sel_idx];
            else             host_rdata <= {{(WORD_W-HI_W){1'b0}}, hi_arr[sel_idx]};
        end
    end

    AST_ONE_TARGET: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        $countones({wr_hi_vec, wr_lo_vec}) <= 1);                        // R2
    AST_HI_UPPER_ZERO: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        (host_rd_en && !host_addr[0]) |=> (host_rdata[31:16] == 16'h0)); // R4
endmodule

// File: tb/station_addr_bank_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, unrelated host and line clocks.
module station_addr_bank_tb_top;
    localparam int N  = 4;
    localparam int AW = $clog2(2 * N);

    logic          host_clk = 1'b0;
    logic          line_clk = 1'b0;
    logic          host_rst_n = 1'b0;
    logic          line_rst_n = 1'b0;
    logic          host_wr_en = 1'b0;
    logic          host_rd_en = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0]   host_wdata = '0;
    logic [3:0]    host_be = '0;
    logic          trig_lane_big = 1'b0;
    logic [31:0]   host_rdata;
    logic [N*48-1:0] line_addr_flat;

    int checks = 0;
    int failures = 0;
    logic mon_on = 1'b0;

    logic [15:0] m_hi   [N];
    logic [31:0] m_lo   [N];
    logic [47:0] m_line [N];
    logic [47:0] m_last [N];

    station_addr_bank #(.NUM_ENTRIES(N)) dut_i (
        .host_clk, .host_rst_n, .host_wr_en, .host_rd_en, .host_addr,
        .host_wdata, .host_be, .trig_lane_big, .host_rdata,
        .line_clk, .line_rst_n, .line_addr_flat
    );

    always #2.5 host_clk = ~host_clk;
    always #3.65 line_clk = ~line_clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] line_of(input int i);
        return line_addr_flat[i*48 +: 48];
    endfunction

    // R9: every change of a line copy must be to the exact triggered value.
    always @(negedge line_clk) begin
        if (mon_on) begin
            for (int i = 0; i < N; i++) begin
                if (line_of(i) !== m_last[i]) begin
                    check("R9 torn or unexpected line value", {16'h0, line_of(i)}, {16'h0, m_line[i]});
                    m_last[i] = line_of(i);
                end
            end
        end
    end

    task automatic wait_lines(input int n);
        repeat (n) @(posedge line_clk);
        #1;
    endtask

    task automatic merge(inout logic [31:0] w, input logic [31:0] d, input logic [3:0] be);
        for (int l = 0; l < 4; l++) if (be[l]) w[l*8 +: 8] = d[l*8 +: 8];
    endtask

    task automatic do_write(input int idx, input bit lo, input logic [31:0] d, input logic [3:0] be);
        logic [31:0] t;
        @(negedge host_clk);
        host_wr_en = 1'b1; host_addr = AW'(2*idx + (lo ? 1 : 0));
        host_wdata = d; host_be = be;
        if (lo) begin
            t = m_lo[idx]; merge(t, d, be); m_lo[idx] = t;
            if (trig_lane_big ? be[0] : be[3]) m_line[idx] = {m_hi[idx], m_lo[idx]};
        end else begin
            t = {16'h0, m_hi[idx]}; merge(t, d, be); m_hi[idx] = t[15:0];
        end
        @(negedge host_clk);
        host_wr_en = 1'b0;
    endtask

    task automatic do_read(input int idx, input bit lo, output logic [31:0] v);
        @(negedge host_clk);
        host_rd_en = 1'b1; host_addr = AW'(2*idx + (lo ? 1 : 0));
        @(negedge host_clk);
        host_rd_en = 1'b0;
        v = host_rdata;
    endtask

    task automatic check_all_lines(input string req);
        for (int i = 0; i < N; i++) check(req, {16'h0, line_of(i)}, {16'h0, m_line[i]});
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int i = 0; i < N; i++) begin
            do_read(i, 0, v); check("R1 upper word reset", {32'h0, v}, 64'h0000FFFF);
            do_read(i, 1, v); check("R1 lower word reset", {32'h0, v}, 64'hFFFFFFFF);
        end
        check_all_lines("R1 line copy reset");
    endtask

    task automatic t_map_and_latency;
        logic [31:0] v;
        do_write(1, 0, 32'h0000_1234, 4'b0011);
        do_write(1, 1, 32'h89AB_CDEF, 4'b1111);
        repeat (4) @(posedge line_clk);
        #1;
        check("R8 R10 latency and value", {16'h0, line_of(1)}, {16'h0, 48'h1234_89AB_CDEF});
        do_read(1, 0, v); check("R2 upper word readback", {32'h0, v}, 64'h0000_1234);
        do_read(1, 1, v); check("R2 lower word readback", {32'h0, v}, 64'h89AB_CDEF);
        check_all_lines("R11 other entries unchanged");
    endtask

    task automatic t_high_upper;
        logic [31:0] v;
        do_write(2, 0, 32'hDEAD_5678, 4'b1111);
        do_read(2, 0, v); check("R4 upper bits zero", {32'h0, v}, 64'h0000_5678);
        wait_lines(8);
        check("R7 high write no transfer", {16'h0, line_of(2)}, {16'h0, 48'hFFFF_FFFF_FFFF});
    endtask

    task automatic t_partial_lanes;
        logic [31:0] v;
        do_write(0, 1, 32'h1122_3344, 4'b0101);
        do_read(0, 1, v); check("R3 lane merge", {32'h0, v}, 64'hFF22_FF44);
        wait_lines(8);
        check("R7 non-trigger lanes no transfer", {16'h0, line_of(0)}, {16'h0, 48'hFFFF_FFFF_FFFF});
        do_write(0, 1, 32'hAA00_0000, 4'b1000);
        wait_lines(5);
        check("R5 R10 lane 3 trigger", {16'h0, line_of(0)}, {16'h0, 48'hFFFF_AA22_FF44});
        check_all_lines("R11 entries independent");
    endtask

    task automatic t_big_mode;
        logic [31:0] v;
        trig_lane_big = 1'b1;
        do_write(3, 0, 32'h0000_BEEF, 4'b0011);
        do_write(3, 1, 32'h5500_0000, 4'b1000);
        wait_lines(8);
        check("R6 lane 3 ignored in big mode", {16'h0, line_of(3)}, {16'h0, 48'hFFFF_FFFF_FFFF});
        do_write(3, 1, 32'h0000_0066, 4'b0001);
        wait_lines(5);
        check("R6 lane 0 trigger", {16'h0, line_of(3)}, {16'h0, 48'hBEEF_55FF_FF66});
        do_read(3, 1, v); check("R3 host copy big mode", {32'h0, v}, 64'h55FF_FF66);
        trig_lane_big = 1'b0;
    endtask

    task automatic t_repeated;
        for (int k = 0; k < 6; k++) begin
            do_write(1, 0, 32'h0000_A000 | k, 4'b0011);
            do_write(1, 1, ~(32'h0101_0101 * k), 4'b1111);
            wait_lines(6);
            check("R9 repeated transfer value", {16'h0, line_of(1)}, {16'h0, m_line[1]});
        end
        check_all_lines("R11 after repeated transfers");
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_hi[i] = '1; m_lo[i] = '1; m_line[i] = '1; m_last[i] = '1;
        end
        repeat (6) @(posedge line_clk);
        @(negedge host_clk);
        host_rst_n = 1'b1;
        @(negedge line_clk);
        line_rst_n = 1'b1;
        mon_on = 1'b1;
        t_reset();
        t_map_and_latency();
        t_high_upper();
        t_partial_lanes();
        t_big_mode();
        t_repeated();
        wait_lines(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule